// File: doc/BRIEF.md
# Pipelined Burst SRAM Port

This block models a synchronous burst SRAM port for simulation and synthesis. A small byte-lane array sits behind it. Each lane is nine bits wide: eight data bits plus one parity bit. There are two ways to start an access, each through its own address strobe. The processor-side strobe always begins a read at the presented address. The controller-side strobe begins a read or a write, chosen by the write controls on the same edge. Once an access has started, the burst-step input moves a two-bit burst counter, and the burst-step and write controls choose whether each following cycle reads or writes. The burst counter runs in linear or interleaved order.

Read data passes through two register stages before it reaches the output. Instead of a three-state pad, the block raises a drive-enable output. Drive is withdrawn when a write is sampled, when the output request is inactive, or while the block sleeps. A sleep input freezes all internal state. After sleep is released, the block ignores a fixed number of cycles before it accepts commands again.

Top module: `psb_sram_port`

## Requirements
- R1: With `sel_n` low and `sel_hi` high, a low `cpu_as_n` on an edge loads `addr` and reads that location, whatever `ctl_as_n` and the write controls are doing.
- R2: On an edge where `cpu_as_n` starts an access, `burst_step_n` and all write controls have no effect: nothing is written and the loaded address is not stepped.
- R3: A low `ctl_as_n` starts an access only when the processor strobe is not in effect on that edge (`cpu_as_n` high, or `sel_n` high). The write controls are sampled on that same edge, and a write goes to the presented address.
- R4: While `sel_n` is high, a low `cpu_as_n` starts nothing and loads no address; the burst in progress continues.
- R5: Data read on edge k appears on `dout` after edge k+1, and not before.
- R6: A low `all_wr_n` writes all lanes, regardless of `lane_gate_n` and `lane_we_n`. Lane i occupies `din`/`dout` bits [9i+8:9i], and bit 9i+8 is its parity bit.
- R7: With `all_wr_n` high and `lane_gate_n` low, exactly the lanes whose `lane_we_n[i]` is 0 are written. With both `all_wr_n` and `lane_gate_n` high, or with no lane enabled, the cycle is a read.
- R8: `drive_en` is low in the cycle after a write is sampled, and whenever `drive_req_n` is high. Otherwise it is high once valid read data is on `dout`.
- R9: During a burst, a low `burst_step_n` advances the two low address bits before the access on that edge, and a high one holds the address. Four steps return to the starting address.
- R10: With `ilv_order` high, the low bits follow start XOR count (interleaved). With it low, they follow start plus count modulo 4 (linear).
- R11: While `sleep` is high, `drive_en` is low at once, no access happens, and `dout` and the array contents hold.
- R12: After `sleep` falls, the next two edges accept no access. The third edge accepts commands.
- R13: After reset, `drive_en` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | Processor-side address strobe, active low |
| ctl_as_n | input | 1 | Controller-side address strobe, active low |
| burst_step_n | input | 1 | Burst advance, active low; high inserts a wait state |
| sel_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_hi | input | 1 | Secondary chip select, active high |
| all_wr_n | input | 1 | Write-all-lanes control, active low |
| lane_gate_n | input | 1 | Enables per-lane writes, active low |
| lane_we_n | input | LANES (4) | Per-lane write enables, active low |
| drive_req_n | input | 1 | Output drive request, active low, asynchronous |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear; asynchronous |
| sleep | input | 1 | Power-down request, active high |
| addr | input | ADDR_W (6) | External start address |
| din | input | LANES*LANE_W (36) | Write data |
| dout | output | LANES*LANE_W (36) | Read data from the output register |
| drive_en | output | 1 | Indicates the data output would be driven |

## Verification
The bench targets where the strobes collide. It presents a processor start together with a controller strobe, burst-step and write-all. A design that honoured any of these would corrupt the location it then reads back, or would show data from the neighbouring address. A processor strobe with the primary select high must leave the burst untouched, or the reread shows the wrong word. Latency is checked on the edge before data is due: a one-stage pipeline would raise `drive_en` a cycle early. The bench walks both burst orders through the wrap. It holds new starts during sleep and through the two wake-up edges, then puts a start on the third edge. A wake window that is too short or too long returns the word from a different address.

// File: rtl/psb_pkg.sv
package psb_pkg;

   // Kind of array access decided on one clock edge.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // Burst sequence: the low address bits for a given start and count.
   function automatic logic [7:0] burst_lo(input logic [7:0] start,
                                           input logic [7:0] count,
                                           input logic       interleave);
      return interleave ? (start ^ count) : (start + count);
   endfunction

endpackage

// File: rtl/psb_burst_ctr.sv
module psb_burst_ctr #(
   parameter int AW = 6,
   parameter int BB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          ilv,
   input  logic [AW-1:0] ld_addr,
   output logic [AW-1:0] cur,
   output logic [AW-1:0] nxt
);
   import psb_pkg::*;

   localparam int HI_W = AW - BB;

   logic [AW-1:0] base_q;
   logic [BB-1:0] cnt_q;
   logic [BB-1:0] cnt_nx;
   logic [7:0]    lo_cur;
   logic [7:0]    lo_nxt;

   if (BB < 1 || BB > 8 || HI_W < 1) begin : g_bad_bb
      $error("psb_burst_ctr: BB must be 1..8 and below AW");
   end

   assign cnt_nx = cnt_q + BB'(1);
   assign lo_cur = burst_lo(8'(base_q[BB-1:0]), 8'(cnt_q), ilv);
   assign lo_nxt = burst_lo(8'(base_q[BB-1:0]), 8'(cnt_nx), ilv);
   assign cur    = {base_q[AW-1:BB], lo_cur[BB-1:0]};
   assign nxt    = {base_q[AW-1:BB], lo_nxt[BB-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= ld_addr;
         cnt_q  <= '0;
      end else if (step) begin
         cnt_q  <= cnt_nx;
      end
   end

   // R1: a loaded address is the current address on the next cycle.
   p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cur == $past(ld_addr)));

   // R9: the next address always shares the upper bits with the current one.
   p_step_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cur[AW-1:BB] == $past(cur[AW-1:BB])));

endmodule

// File: rtl/psb_lane_store.sv
module psb_lane_store #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 64,
   parameter int AW     = 6
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        mask,
   input  logic                    re,
   input  logic [AW-1:0]           a,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("psb_lane_store: DEPTH must equal 2**AW");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (we && mask[i]) begin
            cells[a] <= wdata[i*LANE_W +: LANE_W];
         end
         if (re) begin
            rd_q <= cells[a];
         end
      end

      assign rdata[i*LANE_W +: LANE_W] = rd_q;
   end

   // A read and a write never share an edge.
   always_comb begin
      if (we && re) begin
         a_no_rw_clash_r5: assert (1'b0) else $display("psb_lane_store: read and write on one edge");
      end
   end

endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl #(
   parameter int LANES    = 4,
   parameter int WAKE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_as_n,
   input  logic             ctl_as_n,
   input  logic             burst_step_n,
   input  logic             sel_n,
   input  logic             sel_hi,
   input  logic             all_wr_n,
   input  logic             lane_gate_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic             sleep,
   output logic             load,
   output logic             step,
   output logic             rd_go,
   output logic             wr_go,
   output logic [LANES-1:0] mask
);
   import psb_pkg::*;

   localparam int WCW = (WAKE_CYC > 0) ? $clog2(WAKE_CYC + 1) : 1;

   logic awake;
   logic active_q;
   logic sel_ok;
   logic cpu_eff;
   logic ctl_eff;
   logic strobe;
   logic cont;
   logic wr_req;
   acc_e acc;

   if (LANES < 1) begin : g_bad_lanes
      $error("psb_ctrl: LANES must be at least 1");
   end

   // Wake-up window after sleep is released.
   if (WAKE_CYC > 0) begin : g_wake
      logic [WCW-1:0] wake_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wake_q <= '0;
         end else if (sleep) begin
            wake_q <= WCW'(WAKE_CYC);
         end else if (wake_q != '0) begin
            wake_q <= wake_q - WCW'(1);
         end
      end
      assign awake = !sleep && (wake_q == '0);

      // R12: the first edge after sleep falls never loads an address.
      p_no_load_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sleep) |-> !load);
   end else begin : g_nowake
      assign awake = !sleep;
   end

   // Strobe decoding: the processor strobe is gated by the primary select
   // and has priority over the controller strobe.
   assign sel_ok  = !sel_n && sel_hi;
   assign cpu_eff = !cpu_as_n && !sel_n;
   assign ctl_eff = !ctl_as_n && !cpu_eff;
   assign strobe  = cpu_eff || ctl_eff;
   assign cont    = awake && !strobe && active_q;
   assign load    = awake && strobe && sel_ok;

   // Lane selection for a write.
   always_comb begin
      if (!all_wr_n) begin
         mask = '1;
      end else if (!lane_gate_n) begin
         mask = ~lane_we_n;
      end else begin
         mask = '0;
      end
   end
   assign wr_req = |mask;

   always_comb begin
      acc = ACC_NONE;
      if (load) begin
         acc = (ctl_eff && wr_req) ? ACC_WRITE : ACC_READ;
      end else if (cont) begin
         acc = wr_req ? ACC_WRITE : ACC_READ;
      end
   end

   assign rd_go = (acc == ACC_READ);
   assign wr_go = (acc == ACC_WRITE);
   assign step  = cont && !burst_step_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (awake && strobe) begin
         active_q <= sel_ok;
      end
   end

   // R4: a processor strobe with the primary select off starts nothing.
   p_gated_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && ctl_as_n) |-> !load);

   // R11: no access while asleep.
   p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !(rd_go || wr_go));

endmodule

// File: rtl/psb_out_pipe.sv
module psb_out_pipe #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          rd_go,
   input  logic          wr_go,
   input  logic [DW-1:0] d1,
   output logic [DW-1:0] dout,
   output logic          v2,
   output logic          wflag
);

   logic v1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         v2    <= 1'b0;
         wflag <= 1'b0;
         dout  <= '0;
      end else if (!hold) begin
         v1    <= rd_go;
         v2    <= v1;
         wflag <= wr_go;
         if (v1) begin
            dout <= d1;
         end
      end
   end

   // R5: a read issued on an edge is valid at the output two edges later.
   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && !hold) ##1 !hold |=> v2);

   // R11: a frozen pipeline keeps its output.
   p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(dout));

endmodule

// File: rtl/psb_sram_port.sv
module psb_sram_port #(
   parameter int LANES    = 4,
   parameter int LANE_W   = 9,
   parameter int DEPTH    = 64,
   parameter int BURST_B  = 2,
   parameter int WAKE_CYC = 2,
   parameter int ADDR_W   = $clog2(DEPTH),
   parameter int DW       = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_as_n,
   input  logic              ctl_as_n,
   input  logic              burst_step_n,
   input  logic              sel_n,
   input  logic              sel_hi,
   input  logic              all_wr_n,
   input  logic              lane_gate_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              drive_req_n,
   input  logic              ilv_order,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout,
   output logic              drive_en
);

   if (LANE_W < 2) begin : g_bad_lane_w
      $error("psb_sram_port: LANE_W must hold data plus parity");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("psb_sram_port: DEPTH must be a power of two, at least 4");
   end
   if (BURST_B >= ADDR_W) begin : g_bad_burst
      $error("psb_sram_port: burst field must be narrower than the address");
   end
   if (DW != LANES * LANE_W) begin : g_bad_dw
      $error("psb_sram_port: DW must equal LANES*LANE_W");
   end

   logic              load;
   logic              step;
   logic              rd_go;
   logic              wr_go;
   logic [LANES-1:0]  mask;
   logic [ADDR_W-1:0] cur;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] a_use;
   logic [DW-1:0]     d1;
   logic              v2;
   logic              wflag;

   psb_ctrl #(
      .LANES    (LANES),
      .WAKE_CYC (WAKE_CYC)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_as_n     (cpu_as_n),
      .ctl_as_n     (ctl_as_n),
      .burst_step_n (burst_step_n),
      .sel_n        (sel_n),
      .sel_hi       (sel_hi),
      .all_wr_n     (all_wr_n),
      .lane_gate_n  (lane_gate_n),
      .lane_we_n    (lane_we_n),
      .sleep        (sleep),
      .load         (load),
      .step         (step),
      .rd_go        (rd_go),
      .wr_go        (wr_go),
      .mask         (mask)
   );

   psb_burst_ctr #(
      .AW (ADDR_W),
      .BB (BURST_B)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .ilv     (ilv_order),
      .ld_addr (addr),
      .cur     (cur),
      .nxt     (nxt)
   );

   // Address used on this edge: fresh start, stepped burst or held burst.
   assign a_use = load ? addr : (step ? nxt : cur);

   psb_lane_store #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .DEPTH  (DEPTH),
      .AW     (ADDR_W)
   ) u_store (
      .clk   (clk),
      .we    (wr_go),
      .mask  (mask),
      .re    (rd_go),
      .a     (a_use),
      .wdata (din),
      .rdata (d1)
   );

   psb_out_pipe #(
      .DW (DW)
   ) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (sleep),
      .rd_go (rd_go),
      .wr_go (wr_go),
      .d1    (d1),
      .dout  (dout),
      .v2    (v2),
      .wflag (wflag)
   );

   assign drive_en = v2 && !wflag && !drive_req_n && !sleep;

   // R8: a sampled write turns the drive off on the following cycle.
   p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> !drive_en);

   // R8: no drive without the output request.
   p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drive_req_n |-> !drive_en);

   // R2: a processor-strobe start never writes.
   p_cpu_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_as_n && !sel_n) |-> !wr_go);

   // R11: sleep holds the output data.
   p_sleep_dout_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(dout));

endmodule

// File: tb/sim_psb_sram_port.sv
`timescale 1ns/1ps
module sim_psb_sram_port;

   localparam real HALF = 2.5;

   typedef struct packed {
      logic        cpu_n;
      logic        ctl_n;
      logic        stp_n;
      logic        all_n;
      logic        gate_n;
      logic [3:0]  we_n;
      logic        oe_n;
      logic        ilv;
      logic [5:0]  a;
      logic [35:0] d;
      logic        chk_d;
      logic [35:0] exp_d;
      logic        chk_e;
      logic        exp_e;
      logic [7:0]  req;
   } vec_t;

   localparam logic [35:0] D0 = 36'h1A2B3C4D5;
   localparam logic [35:0] D1 = 36'h2468ACE13;
   localparam logic [35:0] D2 = 36'h3FEDCBA98;
   localparam logic [35:0] D3 = 36'h456789ABC;
   localparam logic [35:0] D4 = 36'h5A5A5A5A5;
   localparam logic [35:0] D5 = 36'hC3C3C3C3C;
   localparam logic [35:0] DJ = 36'hFFFFFFFFF;

   function automatic logic [35:0] lane_mix(input logic [35:0] old_w,
                                            input logic [35:0] new_w,
                                            input logic [3:0]  wmask);
      logic [35:0] r;
      r = old_w;
      for (int i = 0; i < 4; i++) begin
         if (wmask[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
      end
      return r;
   endfunction

   function automatic vec_t mk(input logic cpu_n, input logic ctl_n,
                               input logic stp_n, input logic all_n,
                               input logic gate_n, input logic [3:0] we_n,
                               input logic oe_n, input logic ilv,
                               input logic [5:0] a, input logic [35:0] d,
                               input logic chk_d, input logic [35:0] exp_d,
                               input logic chk_e, input logic exp_e,
                               input logic [7:0] req);
      vec_t v;
      v.cpu_n = cpu_n; v.ctl_n = ctl_n; v.stp_n = stp_n; v.all_n = all_n;
      v.gate_n = gate_n; v.we_n = we_n; v.oe_n = oe_n; v.ilv = ilv;
      v.a = a; v.d = d; v.chk_d = chk_d; v.exp_d = exp_d;
      v.chk_e = chk_e; v.exp_e = exp_e; v.req = req;
      return v;
   endfunction

   localparam int NV = 22;
   // Columns: cpu ctl step all gate we oe ilv addr din | chk_d exp_d chk_e exp_e req
   localparam vec_t TBL [NV] = '{
      mk(1,0,1,0,1,4'hF,0,0,6'h10,D0, 0,'0,1,0, 8'd3),  // R3 controller start write
      mk(1,1,0,0,1,4'hF,0,0,6'h00,D1, 0,'0,1,0, 8'd8),  // R8 write hides drive
      mk(1,1,0,0,1,4'hF,0,0,6'h00,D2, 0,'0,1,0, 8'd8),
      mk(1,1,0,0,1,4'hF,0,0,6'h00,D3, 0,'0,1,0, 8'd8),
      mk(0,0,0,0,1,4'hF,0,0,6'h10,DJ, 0,'0,1,0, 8'd5),  // R5 no data one edge after read
      mk(1,1,1,1,1,4'hF,0,0,6'h00,'0, 1,D0,1,1, 8'd1),  // R1 R2 start read, no write
      mk(1,1,0,1,1,4'hF,0,0,6'h00,'0, 1,D0,1,1, 8'd2),  // R2 no step on start edge
      mk(1,1,0,1,1,4'hF,0,0,6'h00,'0, 1,D1,1,1, 8'd9),  // R9 linear step
      mk(1,1,0,1,1,4'hF,0,0,6'h00,'0, 1,D2,1,1, 8'd9),
      mk(1,1,0,1,1,4'hF,0,0,6'h00,'0, 1,D3,1,1, 8'd9),
      mk(1,1,1,1,1,4'hF,0,0,6'h00,'0, 1,D0,1,1, 8'd9),  // R9 wrap to start
      mk(1,1,1,1,1,4'hF,1,0,6'h00,'0, 1,D0,1,0, 8'd8),  // R8 request off
      mk(0,1,1,1,1,4'hF,0,1,6'h11,'0, 1,D0,1,1, 8'd1),
      mk(1,1,0,1,1,4'hF,0,1,6'h00,'0, 1,D1,1,1, 8'd10), // R10 interleaved
      mk(1,1,0,1,1,4'hF,0,1,6'h00,'0, 1,D0,1,1, 8'd10),
      mk(1,1,0,1,1,4'hF,0,1,6'h00,'0, 1,D3,1,1, 8'd10),
      mk(1,1,1,1,1,4'hF,0,1,6'h00,'0, 1,D2,1,1, 8'd10),
      mk(1,0,1,0,1,4'hF,0,0,6'h20,D4, 0,'0,1,0, 8'd8),
      mk(1,1,1,1,0,4'hA,0,0,6'h00,D5, 0,'0,1,0, 8'd7),  // R7 lanes 0 and 2
      mk(1,1,1,1,1,4'h0,0,0,6'h00,DJ, 0,'0,1,0, 8'd7),  // R7 gate high: read
      mk(1,1,1,1,1,4'hF,0,0,6'h00,'0, 1,lane_mix(D4,D5,4'b0101),1,1, 8'd6), // R6
      mk(1,1,1,1,1,4'hF,0,0,6'h00,'0, 1,lane_mix(D4,D5,4'b0101),1,1, 8'd7)  // R7
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_as_n, ctl_as_n, burst_step_n, sel_n, sel_hi;
   logic        all_wr_n, lane_gate_n, drive_req_n, ilv_order, sleep;
   logic [3:0]  lane_we_n;
   logic [5:0]  addr;
   logic [35:0] din;
   logic [35:0] dout;
   logic        drive_en;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(HALF) clk = ~clk;

   psb_sram_port u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_as_n     (cpu_as_n),
      .ctl_as_n     (ctl_as_n),
      .burst_step_n (burst_step_n),
      .sel_n        (sel_n),
      .sel_hi       (sel_hi),
      .all_wr_n     (all_wr_n),
      .lane_gate_n  (lane_gate_n),
      .lane_we_n    (lane_we_n),
      .drive_req_n  (drive_req_n),
      .ilv_order    (ilv_order),
      .sleep        (sleep),
      .addr         (addr),
      .din          (din),
      .dout         (dout),
      .drive_en     (drive_en)
   );

   task automatic check(input string tag, input logic [35:0] got,
                        input logic [35:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      cpu_as_n = 1; ctl_as_n = 1; burst_step_n = 1; sel_n = 0; sel_hi = 1;
      all_wr_n = 1; lane_gate_n = 1; lane_we_n = 4'hF; drive_req_n = 0;
      ilv_order = 0; addr = '0; din = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      idle();
      sleep = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R13 reset drive_en", 36'(drive_en), 36'd0);
      check("R13 reset dout", dout, '0);
      @(negedge clk);
      rst_n = 1;

      // Vector table
      for (int j = 0; j < NV; j++) begin
         @(negedge clk);
         cpu_as_n = TBL[j].cpu_n; ctl_as_n = TBL[j].ctl_n;
         burst_step_n = TBL[j].stp_n; all_wr_n = TBL[j].all_n;
         lane_gate_n = TBL[j].gate_n; lane_we_n = TBL[j].we_n;
         drive_req_n = TBL[j].oe_n; ilv_order = TBL[j].ilv;
         addr = TBL[j].a; din = TBL[j].d;
         tick();
         if (TBL[j].chk_d)
            check($sformatf("R%0d row %0d dout", TBL[j].req, j), dout, TBL[j].exp_d);
         if (TBL[j].chk_e)
            check($sformatf("R%0d row %0d drive_en", TBL[j].req, j),
                  36'(drive_en), 36'(TBL[j].exp_e));
      end

      // R4: processor strobe with primary select off leaves the burst alone
      @(negedge clk); idle(); cpu_as_n = 0; addr = 6'h10;
      tick();
      @(negedge clk); idle(); sel_n = 1; cpu_as_n = 0; addr = 6'h13;
      tick();
      @(negedge clk); idle();
      tick();
      check("R4 burst kept", dout, D0);
      check("R4 drive_en", 36'(drive_en), 36'd1);

      // R11: sleep freezes, blocks a write, drops drive at once
      begin
         logic [35:0] held;
         @(negedge clk);
         held = dout;
         sleep = 1; ctl_as_n = 0; all_wr_n = 0; addr = 6'h10; din = DJ;
         #0.5;
         check("R11 drive off async", 36'(drive_en), 36'd0);
         for (int k = 0; k < 3; k++) begin
            tick();
            check("R11 dout held", dout, held);
         end
      end

      // R12: starts on the two wake edges are ignored
      @(negedge clk); idle(); sleep = 0; cpu_as_n = 0; addr = 6'h13;
      tick();
      @(negedge clk);
      tick();
      @(negedge clk); idle();
      tick();
      @(negedge clk);
      tick();
      check("R12 wake starts ignored, R11 no write", dout, D0);
      check("R12 drive after wake", 36'(drive_en), 36'd1);

      // R12: a start on the third edge is accepted
      @(negedge clk); sleep = 1;
      tick();
      @(negedge clk); idle(); sleep = 0;
      tick();
      @(negedge clk);
      tick();
      @(negedge clk); cpu_as_n = 0; addr = 6'h12;
      tick();
      @(negedge clk); idle();
      tick();
      check("R12 third edge start", dout, D2);

      // R3: controller strobe refused while processor strobe is low
      @(negedge clk); idle(); cpu_as_n = 0; ctl_as_n = 0; all_wr_n = 0;
      addr = 6'h11; din = DJ;
      tick();
      @(negedge clk); idle();
      tick();
      @(negedge clk);
      tick();
      check("R3 controller strobe refused", dout, D1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule